// File: doc/BRIEF.md
# Prioritised Locality Ownership Arbiter

This block decides which of five localities (software privilege contexts sharing one register window) currently owns a shared command interface. Each locality sees the same small register page, repeated every 4 KB. The page index above the offset bits names the locality. One byte-wide access register per locality lets software ask for ownership, give it up, take it by force from a lower locality, and acknowledge that it was displaced.

Reads of that register show a locality's own flags, the fact that it owns the interface, and whether any other locality is waiting. When ownership would change hands while the command engine is busy, the arbiter does not switch at once. It raises an abort request and finishes the handover only after the engine acknowledges it. Ownership changes are reported on a one-cycle pulse that an interrupt controller can consume.

Top module: `loc_arbiter`

## Requirements
- R1: The locality is `addr[LOC_SHIFT+2:LOC_SHIFT]` and is valid for values 0 to 4. The access register sits at page offset 0. A read of any other offset, or of locality 5 to 7, returns 0x00, and writes to those addresses have no effect.
- R2: Writes from locality 4 never change any state. Reads from locality 4 work normally.
- R3: A write with bit 1 (request) from a non-owner grants ownership at once when no owner exists. When another locality owns the interface, the write instead sets the writer's request flag. A request written by the owner has no effect.
- R4: A write with bit 5 (release) from the owner passes ownership to the highest-numbered locality whose request flag is set, or to no locality if none is set. On this normal handover the old owner loses both ownership and its request flag.
- R5: A release write from a locality that is not the owner only clears that locality's request flag.
- R6: A write with bit 3 (seize) is accepted only when no owner exists or the writer is numbered above the owner, the writer has no seize pending, and no higher locality has a seize pending. An accepted seize cancels the pending seizes of all lower localities, so at most one seize is ever pending.
- R7: On a handover caused by a seize, the old owner keeps its request flag and gains a sticky displaced flag. A write with bit 4 from a locality clears its own displaced flag.
- R8: The new owner's request and seize flags are cleared. `loc_changed` pulses for exactly one cycle, in the cycle after every edge at which the owner or its validity changes, and at no other time.
- R9: A read returns, one cycle after `rd_en`, bit 7 = 1 (register valid), bit 5 = reader is owner, bit 4 = displaced, bit 2 = some other locality has its request flag set, bit 1 = own request flag. Bits 6, 3 and 0 always read 0, so a pending seize is never visible.
- R10: A handover by release or seize while `cmd_busy` is high raises `abort_req` and leaves the owner unchanged. `abort_req` and the owner stay fixed until `abort_ack`, which performs the handover to the latest accepted target and drops `abort_req`. While an abort is pending, release writes are dropped. Seize writes may still retarget it under R6.
- R11: Reset leaves no owner, no abort request, and every locality's register reading 0x80.
- R12: A write performs one action, with priority seize, then release, then request. A lower-priority action bit is ignored when a higher one is present. The displaced-clear bit applies in any combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe for `addr` |
| addr | input | LOC_SHIFT+3 | Locality page and offset |
| wdata | input | 8 | Write data for the access register |
| cmd_busy | input | 1 | Command engine is executing |
| abort_ack | input | 1 | Engine has stopped the running command |
| rdata | output | 8 | Registered read data |
| abort_req | output | 1 | Handover waiting for the engine |
| owner_valid | output | 1 | Some locality owns the interface |
| owner_id | output | 3 | Owning locality when `owner_valid` |
| loc_changed | output | 1 | One-cycle pulse on ownership change |

## Verification
The assertions assume that `abort_ack` comes only while `abort_req` is high. They also assume it never comes in the same cycle as a register write. The owner-hold property only restricts cycles without an acknowledge. Stimulus follows this rule: every acknowledge is a single isolated pulse, driven while the bus is idle, after the abort request has been seen. Every access is a single strobe applied between clock edges, with reads and writes never overlapping.

// File: rtl/loc_arb_pkg.sv
`timescale 1ns/1ps
package loc_arb_pkg;
  localparam int NUM_LOC = 5;
  localparam int LOC_W   = 3;

  // access register bit positions
  localparam int B_REQ    = 1;
  localparam int B_PEND   = 2;
  localparam int B_SEIZE  = 3;
  localparam int B_SEIZED = 4;
  localparam int B_ACTIVE = 5;
  localparam int B_VALID  = 7;

  typedef struct packed {
    logic [NUM_LOC-1:0] req;
    logic [NUM_LOC-1:0] seize;
    logic [NUM_LOC-1:0] seized;
    logic               ov;
    logic [LOC_W-1:0]   own;
    logic               abort;
    logic [LOC_W-1:0]   tgt;
    logic               chg;
  } arb_st_t;

  // move ownership to n (or to nobody when nv is low)
  function automatic arb_st_t hand(arb_st_t s, logic nv, logic [LOC_W-1:0] n);
    arb_st_t r;
    logic    c;
    r = s;
    c = (s.ov != nv) || (nv && (s.own != n));
    if (s.ov && c) begin
      if (nv && s.seize[n]) r.seized[s.own] = 1'b1;
      else                  r.req[s.own]    = 1'b0;
    end
    r.ov  = nv;
    r.own = nv ? n : '0;
    if (nv) begin
      r.req[n]   = 1'b0;
      r.seize[n] = 1'b0;
    end
    r.chg = s.chg | c;
    return r;
  endfunction

  // hand over now, or park the target behind an abort request
  function automatic arb_st_t prep(arb_st_t s, logic [LOC_W-1:0] n, logic busy);
    arb_st_t r;
    if (busy || s.abort) begin
      r       = s;
      r.abort = 1'b1;
      r.tgt   = n;
    end else begin
      r = hand(s, 1'b1, n);
    end
    return r;
  endfunction
endpackage

// File: rtl/loc_decode.sv
`timescale 1ns/1ps
module loc_decode
  import loc_arb_pkg::*;
#(
  parameter int LOC_SHIFT = 12,
  parameter int ADDR_W    = LOC_SHIFT + LOC_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LOC_W-1:0]  loc,
  output logic              loc_ok,
  output logic              reg_hit,
  output logic              wr_ok
);
  assign loc     = addr[ADDR_W-1:LOC_SHIFT];
  assign loc_ok  = loc < LOC_W'(NUM_LOC);
  assign reg_hit = (addr[LOC_SHIFT-1:0] == '0);
  // the top locality is read-only
  assign wr_ok   = loc_ok && reg_hit && (loc != LOC_W'(NUM_LOC-1));
endmodule

// File: rtl/req_scan.sv
`timescale 1ns/1ps
module req_scan
  import loc_arb_pkg::*;
(
  input  logic [NUM_LOC-1:0] req,
  input  logic [NUM_LOC-1:0] seize,
  output logic               hi_any,
  output logic [LOC_W-1:0]   hi_idx,
  output logic [NUM_LOC-1:0] pend_other,
  output logic [NUM_LOC-1:0] seize_above
);
  always_comb begin
    hi_any = 1'b0;
    hi_idx = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (req[i]) begin
        hi_any = 1'b1;
        hi_idx = LOC_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    assign pend_other[g]  = |(req & ~(NUM_LOC'(1) << g));
    assign seize_above[g] = |(seize >> (g + 1));
  end
endmodule

// File: rtl/arb_core.sv
`timescale 1ns/1ps
module arb_core
  import loc_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [LOC_W-1:0]   wloc,
  input  logic               c_seize,
  input  logic               c_release,
  input  logic               c_request,
  input  logic               c_clr_seized,
  input  logic               cmd_busy,
  input  logic               abort_ack,
  input  logic               hi_any,
  input  logic [LOC_W-1:0]   hi_idx,
  input  logic [NUM_LOC-1:0] seize_above,
  output arb_st_t            st,
  output logic               loc_changed
);
  arb_st_t            n;
  logic               own_w;
  logic [NUM_LOC-1:0] lower_mask;

  always_comb begin
    n          = st;
    n.chg      = 1'b0;
    own_w      = st.ov && (st.own == wloc);
    lower_mask = (NUM_LOC'(1) << wloc) - NUM_LOC'(1);
    if (st.abort && abort_ack) begin
      n       = hand(n, 1'b1, st.tgt);
      n.abort = 1'b0;
    end
    if (wr) begin
      if (c_clr_seized) n.seized[wloc] = 1'b0;
      if (c_seize) begin
        if ((!st.ov || (wloc > st.own)) && !st.seize[wloc] && !seize_above[wloc]) begin
          n.seize       = n.seize & ~lower_mask;
          n.seize[wloc] = 1'b1;
          n             = prep(n, wloc, cmd_busy);
        end
      end else if (c_release) begin
        if (own_w) begin
          if (!st.abort) begin
            if (hi_any) n = prep(n, hi_idx, cmd_busy);
            else        n = hand(n, 1'b0, '0);
          end
        end else begin
          n.req[wloc] = 1'b0;
        end
      end else if (c_request) begin
        if (!own_w) begin
          if (st.ov || st.abort) n.req[wloc] = 1'b1;
          else                   n = hand(n, 1'b1, wloc);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= '0;
      loc_changed <= 1'b0;
    end else begin
      st          <= n;
      loc_changed <= n.chg;
    end
  end

  // R1: owner index always names a real locality
  a_r1_owner_range: assert property (@(posedge clk) disable iff (rst)
    st.ov |-> (st.own < LOC_W'(NUM_LOC)));
  // R6: lower seizes are cancelled, higher ones block
  a_r6_single_seize: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st.seize));
  // R7: displaced flag appears only together with a handover
  a_r7_seized_on_change: assert property (@(posedge clk) disable iff (rst)
    (|(st.seized & ~$past(st.seized))) |-> loc_changed);
  // R8: change pulse only when owner actually moved
  a_r8_pulse_real: assert property (@(posedge clk) disable iff (rst)
    loc_changed |-> ((st.ov != $past(st.ov)) || (st.own != $past(st.own))));
  // R8: owner carries no request or seize flag
  a_r8_owner_clean: assert property (@(posedge clk) disable iff (rst)
    st.ov |-> (!st.req[st.own] && !st.seize[st.own]));
  // R10: abort request held until acknowledged
  a_r10_abort_hold: assert property (@(posedge clk) disable iff (rst)
    (st.abort && !abort_ack) |=> st.abort);
  // R10: owner frozen while abort pending
  a_r10_owner_hold: assert property (@(posedge clk) disable iff (rst)
    (st.abort && !abort_ack) |=> ($stable(st.ov) && $stable(st.own)));
endmodule

// File: rtl/loc_arbiter.sv
`timescale 1ns/1ps
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int LOC_SHIFT = 12,
  localparam int ADDR_W   = LOC_SHIFT + LOC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              cmd_busy,
  input  logic              abort_ack,
  output logic [7:0]        rdata,
  output logic              abort_req,
  output logic              owner_valid,
  output logic [LOC_W-1:0]  owner_id,
  output logic              loc_changed
);
  logic [LOC_W-1:0]   loc;
  logic               loc_ok, reg_hit, wr_ok;
  logic               hi_any;
  logic [LOC_W-1:0]   hi_idx;
  logic [NUM_LOC-1:0] pend_other, seize_above;
  arb_st_t            st;
  logic [7:0]         rd_word;
  logic               unused_bits;

  assign unused_bits = ^{wdata[7:6], wdata[B_PEND], wdata[0]};

  loc_decode #(.LOC_SHIFT(LOC_SHIFT), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .loc(loc), .loc_ok(loc_ok), .reg_hit(reg_hit), .wr_ok(wr_ok)
  );

  req_scan u_scan (
    .req(st.req), .seize(st.seize), .hi_any(hi_any), .hi_idx(hi_idx),
    .pend_other(pend_other), .seize_above(seize_above)
  );

  arb_core u_core (
    .clk(clk), .rst(rst), .wr(wr_en && wr_ok), .wloc(loc),
    .c_seize(wdata[B_SEIZE]), .c_release(wdata[B_ACTIVE]),
    .c_request(wdata[B_REQ]), .c_clr_seized(wdata[B_SEIZED]),
    .cmd_busy(cmd_busy), .abort_ack(abort_ack),
    .hi_any(hi_any), .hi_idx(hi_idx), .seize_above(seize_above),
    .st(st), .loc_changed(loc_changed)
  );

  always_comb begin
    rd_word = '0;
    if (loc_ok && reg_hit) begin
      rd_word[B_VALID]  = 1'b1;
      rd_word[B_ACTIVE] = st.ov && (st.own == loc);
      rd_word[B_SEIZED] = st.seized[loc];
      rd_word[B_PEND]   = pend_other[loc];
      rd_word[B_REQ]    = st.req[loc];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  assign abort_req   = st.abort;
  assign owner_valid = st.ov;
  assign owner_id    = st.own;

  // R9: a pending seize never leaks onto the read bus after a read
  a_r9_seize_hidden: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en) |-> (rdata[B_SEIZE] == 1'b0 && rdata[6] == 1'b0 && rdata[0] == 1'b0));
  // R2: a write from the top locality never moves ownership
  a_r2_top_readonly: assert property (@(posedge clk) disable iff (rst)
    (wr_en && loc == LOC_W'(NUM_LOC-1) && !(abort_req && abort_ack)) |=>
      ($stable(owner_valid) && $stable(owner_id)));
endmodule

// File: tb/tb_loc_arbiter.sv
`timescale 1ns/1ps
module tb_loc_arbiter;
  localparam int SH = 12;
  localparam int AW = SH + 3;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, cmd_busy = 0, abort_ack = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic abort_req, owner_valid, loc_changed;
  logic [2:0] owner_id;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  loc_arbiter #(.LOC_SHIFT(SH)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cmd_busy(cmd_busy), .abort_ack(abort_ack), .rdata(rdata),
    .abort_req(abort_req), .owner_valid(owner_valid), .owner_id(owner_id),
    .loc_changed(loc_changed)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data once the registered result is out
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("monitor underflow", 1, 0);
      else chk(tag_q.pop_front(), int'(rdata), int'(exp_q.pop_front()));
    end
  end

  task automatic wr(int loc, logic [7:0] d);
    @(negedge clk);
    addr = AW'(loc * 4096); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int loc, int off, logic [7:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    addr = AW'(loc * 4096 + off); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); abort_ack = 1'b1;
    @(negedge clk); abort_ack = 1'b0;
  endtask

  task automatic own(string tag, int v, int id);
    chk({tag, " owner_valid"}, int'(owner_valid), v);
    if (v != 0) chk({tag, " owner_id"}, int'(owner_id), id);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    own("R11 reset", 0, 0);
    chk("R11 abort_req", int'(abort_req), 0);
    rd(0, 0, 8'h80, "R11 reset read");
    // R3 immediate grant
    wr(2, 8'h02);
    own("R3 grant", 1, 2);
    chk("R8 pulse on grant", int'(loc_changed), 1);
    rd(2, 0, 8'hA0, "R9 owner read");
    // R3 request while owned
    wr(1, 8'h02);
    chk("R8 no pulse on request", int'(loc_changed), 0);
    rd(1, 0, 8'h82, "R3 request flag");
    rd(2, 0, 8'hA4, "R9 pending at owner");
    rd(0, 0, 8'h84, "R9 pending at idle");
    wr(3, 8'h02);
    wr(2, 8'h02);
    rd(2, 0, 8'hA4, "R3 owner request no effect");
    // R2 top locality write ignored, R1 decode
    wr(4, 8'h02);
    rd(4, 0, 8'h84, "R2 top write ignored");
    rd(0, 4, 8'h00, "R1 other offset");
    rd(6, 0, 8'h00, "R1 invalid locality");
    // R4 release to highest requester
    wr(2, 8'h20);
    own("R4 highest requester", 1, 3);
    chk("R8 pulse on release", int'(loc_changed), 1);
    rd(3, 0, 8'hA4, "R8 new owner flags");
    rd(2, 0, 8'h84, "R4 old owner cleared");
    // R5 non-owner release
    wr(1, 8'h20);
    rd(1, 0, 8'h80, "R5 withdraw request");
    // R6 lower seize rejected
    wr(1, 8'h08);
    own("R6 lower seize rejected", 1, 3);
    // R4 release with no requester
    wr(3, 8'h20);
    own("R4 release to none", 0, 0);
    rd(3, 0, 8'h80, "R4 released read");
    // R7 seize handover
    wr(0, 8'h02);
    own("R3 grant loc0", 1, 0);
    wr(1, 8'h08);
    own("R7 seize taken", 1, 1);
    chk("R8 pulse on seize", int'(loc_changed), 1);
    rd(0, 0, 8'h90, "R7 displaced flag");
    rd(1, 0, 8'hA0, "R8 seizer flags");
    wr(0, 8'h10);
    rd(0, 0, 8'h80, "R7 displaced cleared");
    // R10 seize while busy, R6 retarget and blocking
    cmd_busy = 1'b1;
    wr(2, 8'h08);
    chk("R10 abort raised", int'(abort_req), 1);
    own("R10 owner held", 1, 1);
    wr(3, 8'h08);
    wr(2, 8'h08);
    chk("R10 abort still held", int'(abort_req), 1);
    ack();
    own("R6 higher seize wins", 1, 3);
    chk("R10 abort dropped", int'(abort_req), 0);
    chk("R8 pulse on ack", int'(loc_changed), 1);
    rd(1, 0, 8'h90, "R7 seized owner flags");
    // R10 release while busy
    wr(2, 8'h02);
    rd(3, 0, 8'hA4, "R9 pending before release");
    wr(3, 8'h20);
    chk("R10 release abort", int'(abort_req), 1);
    wr(3, 8'h20);
    own("R10 release held", 1, 3);
    ack();
    own("R10 release done", 1, 2);
    rd(3, 0, 8'h80, "R4 normal handover clears");
    rd(2, 0, 8'hA0, "R8 requester now owner");
    cmd_busy = 1'b0;
    // R12 action priority
    wr(1, 8'h2A);
    rd(1, 0, 8'h90, "R12 seize dominates");
    own("R12 owner kept", 1, 2);
    wr(3, 8'h02);
    rd(3, 0, 8'h82, "R12 request set");
    wr(3, 8'h22);
    rd(3, 0, 8'h80, "R12 release dominates request");
    // R11 reset again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    own("R11 second reset", 0, 0);
    rd(1, 0, 8'h80, "R11 flags cleared");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule